// File: doc/BRIEF.md
# Two-Unit Single-Shot SAR Conversion Controller

This block runs one conversion at a time on each of two successive-approximation converter units. Software picks a single input pad through a one-hot bitmap. It also chooses a result width code and an invert option, then raises the unit's start bit. The controller sees the rising edge and checks the bitmap. If the bitmap is valid, it issues a request to the converter carrying the binary channel index and that channel's attenuation setting. It then waits for the converter's acknowledge.

On acknowledge the controller loads the raw sample into the unit's result register, reduced to the selected width and optionally complemented. In the same cycle it raises the unit's done event. The two units differ in one respect. Unit 1 holds a start edge that arrives while it is busy and launches it once the running conversion ends. Unit 2 drops such an edge.

A shared attenuation bank keeps a 2-bit setting per channel and per unit. Each write touches exactly one channel's field.

Top module: `sar_oneshot_ctrl`

## Requirements
- R1: After synchronous active-low reset, every bit of `done_o`, `busy_o`, `conv_req_o` and `result_o` is 0, and the attenuation words of both units read as zero.
- R2: A conversion launches on the clock edge where a unit's start bit is seen at 1 after being 0. From the next cycle, `busy_o` and `conv_req_o` are 1 for that unit and `conv_chan_o` carries the binary index of the set bitmap bit. Holding the start bit at 1 does not launch again.
- R3: A start edge whose bitmap is all zeros or has more than one bit set is ignored. No request follows and the done flag keeps its value.
- R4: The result equals the 12-bit raw sample shifted right by (3 − code), so code 0 gives 9 bits, 1 gives 10, 2 gives 11 and 3 gives 12. All bits above the selected width read 0.
- R5: With the unit's invert bit set at launch, the result is complemented within the selected width only.
- R6: `done_o[0]` belongs to unit 1 and `done_o[1]` to unit 2. A unit's flag clears on the edge that accepts a start. It sets on the edge where the acknowledge is sampled, together with the result load.
- R7: On unit 1, a start edge that arrives while busy is held. The held start is launched in the cycle after the running conversion completes, using the bitmap, code and invert values present at that moment.
- R8: On unit 2, a start edge that arrives while busy is discarded. After the running conversion completes, the unit stays idle.
- R9: An attenuation write with unit u, channel c and value v sets bits [2c+1:2c] of unit u's attenuation word to v and leaves every other field unchanged. The word is read back through `att_rd_word_o`. A launched request carries the selected channel's field on `conv_atten_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 2 | Start bits, bit u for unit u+1 |
| pad_map_i | input | 2*NCH | One-hot pad bitmaps, unit u at [u*NCH +: NCH] |
| width_code_i | input | 4 | Result width codes, unit u at [2u+1:2u] |
| invert_i | input | 2 | Per-unit invert enable |
| att_we_i | input | 1 | Attenuation write strobe |
| att_unit_i | input | 1 | Unit addressed by the write |
| att_chan_i | input | CHW | Channel addressed by the write |
| att_val_i | input | 2 | Attenuation value to store |
| att_rd_unit_i | input | 1 | Unit whose attenuation word is read |
| att_rd_word_o | output | 2*NCH | Attenuation word of the read unit |
| conv_req_o | output | 2 | Conversion request per unit |
| conv_chan_o | output | 2*CHW | Binary channel index per unit |
| conv_atten_o | output | 4 | Attenuation of the selected channel per unit |
| conv_ack_i | input | 2 | Converter acknowledge per unit |
| conv_data_i | input | 2*DW | Raw converter samples, unit u at [u*DW +: DW] |
| done_o | output | 2 | Done events, bit 0 unit 1, bit 1 unit 2 |
| busy_o | output | 2 | Measurement status per unit |
| result_o | output | 2*DW | Formatted results, unit u at [u*DW +: DW] |

## Verification
The hardest case to reach is a start edge that lands inside a running conversion. On unit 1 it must be held and relaunched; on unit 2 it must vanish. Neither outcome shows unless the edge falls strictly between launch and acknowledge. The bench therefore gives its converter stub a long acknowledge latency. It toggles the start bit low and high while `busy_o` is observed high, and changes the bitmap at the same time so that the relaunched request can be told apart by its channel index.

// File: rtl/sar_oneshot_pkg.sv
// Package: shared constants and types for the single-shot SAR controller.
// Assumes the widest result is DW bits and the narrowest DW-3 bits.
package sar_oneshot_pkg;
    localparam int NUM_UNITS = 2;
    localparam int WCODE_SPAN = 3;

    typedef enum logic [1:0] {
        WC_9B  = 2'd0,
        WC_10B = 2'd1,
        WC_11B = 2'd2,
        WC_12B = 2'd3
    } wcode_e;
endpackage

// File: rtl/sar_result_fmt.sv
// Result formatter: reduces a full-width raw sample to the width chosen by
// a 2-bit code, then optionally complements the kept bits.
// Assumes code 3 keeps all DW bits; each lower code drops one more LSB.
module sar_result_fmt #(
    parameter int DW = 12
) (
    input  logic [DW-1:0] raw_i,
    input  logic [1:0]    code_i,
    input  logic          invert_i,
    output logic [DW-1:0] fmt_o
);
    logic [DW-1:0] keep_mask;
    logic [DW-1:0] shifted;

    // Shift and mask within the selected width.
    always_comb begin
        keep_mask = {DW{1'b1}} >> (2'd3 - code_i);
        shifted   = raw_i >> (2'd3 - code_i);
        fmt_o     = (shifted ^ (invert_i ? keep_mask : '0)) & keep_mask;
    end
endmodule

// File: rtl/sar_atten_bank.sv
// Attenuation bank: one 2-bit field per channel per unit, field of channel c
// at bits [2c+1:2c]. A write touches one field only.
// Assumes writes to channels >= NCH are discarded.
module sar_atten_bank #(
    parameter int NCH = 10,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = 2 * NCH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          unit_i,
    input  logic [CHW-1:0] chan_i,
    input  logic [1:0]    val_i,
    input  logic          rd_unit_i,
    output logic [AW-1:0] rd_word_o,
    output logic [2*AW-1:0] words_o
);
    logic [AW-1:0] bank_q [2];

    // Per-field write of the addressed unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q[0] <= '0;
            bank_q[1] <= '0;
        end else if (we_i && (32'(chan_i) < NCH)) begin
            bank_q[unit_i][2*chan_i +: 2] <= val_i;
        end
    end

    // Expose words for readback and for the sequencers.
    always_comb begin
        rd_word_o = bank_q[rd_unit_i];
        words_o   = {bank_q[1], bank_q[0]};
    end

    // R9: the addressed field holds the written value one cycle later.
    a_r9_field_written: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (32'(chan_i) < NCH)) |=>
        (2'(bank_q[$past(unit_i)] >> (2 * $past(chan_i))) == $past(val_i)));
endmodule

// File: rtl/sar_unit_seq.sv
// Per-unit sequencer: detects a start rising edge, validates the one-hot pad
// bitmap, runs a request/acknowledge exchange with the converter and loads
// the formatted result while raising done.
// Assumes the converter pulses ack for one cycle while req is high.
// HOLD_BUSY=1 keeps a start edge seen while busy; 0 drops it.
module sar_unit_seq #(
    parameter int NCH       = 10,
    parameter int DW        = 12,
    parameter bit HOLD_BUSY = 1'b1,
    localparam int CHW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NCH-1:0]  pad_map_i,
    input  logic [1:0]      code_i,
    input  logic            invert_i,
    input  logic [2*NCH-1:0] atten_word_i,
    input  logic            ack_i,
    input  logic [DW-1:0]   data_i,
    output logic            busy_o,
    output logic [CHW-1:0]  chan_o,
    output logic [1:0]      atten_o,
    output logic            done_o,
    output logic [DW-1:0]   result_o
);
    logic           start_q;
    logic           busy_q;
    logic           pend_q;
    logic [CHW-1:0] chan_q;
    logic [1:0]     code_q;
    logic           inv_q;
    logic [CHW-1:0] chan_enc;
    logic           map_ok;
    logic           edge_seen;
    logic           try_launch;
    logic [DW-1:0]  fmt_val;

    // Binary index of the bitmap and its one-hot check.
    always_comb begin
        chan_enc = '0;
        for (int i = 0; i < NCH; i++) begin
            if (pad_map_i[i]) chan_enc = CHW'(i);
        end
        map_ok     = (pad_map_i != '0) && ((pad_map_i & (pad_map_i - 1'b1)) == '0);
        edge_seen  = start_i && !start_q;
        try_launch = !busy_q && (edge_seen || pend_q);
    end

    sar_result_fmt #(.DW(DW)) u_fmt (
        .raw_i   (data_i),
        .code_i  (code_q),
        .invert_i(inv_q),
        .fmt_o   (fmt_val)
    );

    // Launch, completion and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            busy_q   <= 1'b0;
            chan_q   <= '0;
            code_q   <= 2'd3;
            inv_q    <= 1'b0;
            done_o   <= 1'b0;
            result_o <= '0;
        end else begin
            start_q <= start_i;
            if (try_launch && map_ok) begin
                busy_q <= 1'b1;
                chan_q <= chan_enc;
                code_q <= code_i;
                inv_q  <= invert_i;
                done_o <= 1'b0;
            end else if (busy_q && ack_i) begin
                busy_q   <= 1'b0;
                result_o <= fmt_val;
                done_o   <= 1'b1;
            end
        end
    end

    // Pending start: kept on the holding unit, absent on the dropping unit.
    generate
        if (HOLD_BUSY) begin : g_hold
            // Remember an edge that arrives during a conversion.
            always_ff @(posedge clk) begin
                if (!rst_n)                 pend_q <= 1'b0;
                else if (busy_q && edge_seen) pend_q <= 1'b1;
                else if (!busy_q)           pend_q <= 1'b0;
            end
        end else begin : g_drop
            assign pend_q = 1'b0;
        end
    endgenerate

    assign busy_o  = busy_q;
    assign chan_o  = chan_q;
    assign atten_o = 2'(atten_word_i >> (2 * chan_q));

    // R6: done rises only on an acknowledge taken while busy.
    a_r6_done_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(ack_i && busy_q));
    // R4: bits above the selected width stay zero while done is shown.
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((result_o >> (DW - 3 + int'(code_q))) == '0));
    // R2: the channel index does not move during a conversion.
    a_r2_chan_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(chan_o));
    // R3: a launch only follows a one-hot bitmap.
    a_r3_onehot_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past($onehot(pad_map_i)));
endmodule

// File: rtl/sar_oneshot_ctrl.sv
// Top: two single-shot sequencers sharing one attenuation bank. Unit 1
// (index 0) holds a start seen while busy; unit 2 (index 1) drops it.
// Assumes packed per-unit fields, unit u at slice u of each bus.
module sar_oneshot_ctrl #(
    parameter int NCH = 10,
    parameter int DW  = 12,
    localparam int CHW = $clog2(NCH),
    localparam int NU  = sar_oneshot_pkg::NUM_UNITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NU-1:0]    start_i,
    input  logic [NU*NCH-1:0] pad_map_i,
    input  logic [2*NU-1:0]  width_code_i,
    input  logic [NU-1:0]    invert_i,
    input  logic             att_we_i,
    input  logic             att_unit_i,
    input  logic [CHW-1:0]   att_chan_i,
    input  logic [1:0]       att_val_i,
    input  logic             att_rd_unit_i,
    output logic [2*NCH-1:0] att_rd_word_o,
    output logic [NU-1:0]    conv_req_o,
    output logic [NU*CHW-1:0] conv_chan_o,
    output logic [2*NU-1:0]  conv_atten_o,
    input  logic [NU-1:0]    conv_ack_i,
    input  logic [NU*DW-1:0] conv_data_i,
    output logic [NU-1:0]    done_o,
    output logic [NU-1:0]    busy_o,
    output logic [NU*DW-1:0] result_o
);
    logic [2*2*NCH-1:0] att_words;

    sar_atten_bank #(.NCH(NCH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (att_we_i),
        .unit_i   (att_unit_i),
        .chan_i   (att_chan_i),
        .val_i    (att_val_i),
        .rd_unit_i(att_rd_unit_i),
        .rd_word_o(att_rd_word_o),
        .words_o  (att_words)
    );

    generate
        for (genvar u = 0; u < NU; u++) begin : g_unit
            sar_unit_seq #(
                .NCH(NCH), .DW(DW), .HOLD_BUSY(u == 0)
            ) u_seq (
                .clk         (clk),
                .rst_n       (rst_n),
                .start_i     (start_i[u]),
                .pad_map_i   (pad_map_i[u*NCH +: NCH]),
                .code_i      (width_code_i[2*u +: 2]),
                .invert_i    (invert_i[u]),
                .atten_word_i(att_words[u*2*NCH +: 2*NCH]),
                .ack_i       (conv_ack_i[u]),
                .data_i      (conv_data_i[u*DW +: DW]),
                .busy_o      (busy_o[u]),
                .chan_o      (conv_chan_o[u*CHW +: CHW]),
                .atten_o     (conv_atten_o[2*u +: 2]),
                .done_o      (done_o[u]),
                .result_o    (result_o[u*DW +: DW])
            );
            assign conv_req_o[u] = busy_o[u];
        end
    endgenerate

    // R1: request and done never show together on a unit.
    a_r1_req_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o & done_o) == '0);
endmodule

// File: tb/sar_oneshot_ctrl_tb.sv
// Directed bench: a behavioural converter stub answers each request after a
// programmable latency; one task per scenario checks its own results.
module sar_oneshot_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 10;
    localparam int DW  = 12;
    localparam int CHW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] start = '0;
    logic [2*NCH-1:0] pad_map = '0;
    logic [3:0] wcode = 4'hF;
    logic [1:0] inv_en = '0;
    logic att_we = 1'b0, att_unit = 1'b0, att_rd_unit = 1'b0;
    logic [CHW-1:0] att_chan = '0;
    logic [1:0] att_val = '0;
    logic [2*NCH-1:0] att_rd_word;
    logic [1:0] conv_req, conv_ack = '0, done, busy;
    logic [2*CHW-1:0] conv_chan;
    logic [3:0] conv_atten;
    logic [2*DW-1:0] conv_data, result;
    logic [DW-1:0] stub_data [2];
    int lat [2];
    int cnt [2];
    int n_chk = 0, n_fail = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_oneshot_ctrl #(.NCH(NCH), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pad_map_i(pad_map),
        .width_code_i(wcode), .invert_i(inv_en), .att_we_i(att_we),
        .att_unit_i(att_unit), .att_chan_i(att_chan), .att_val_i(att_val),
        .att_rd_unit_i(att_rd_unit), .att_rd_word_o(att_rd_word),
        .conv_req_o(conv_req), .conv_chan_o(conv_chan), .conv_atten_o(conv_atten),
        .conv_ack_i(conv_ack), .conv_data_i(conv_data), .done_o(done),
        .busy_o(busy), .result_o(result)
    );

    assign conv_data = {stub_data[1], stub_data[0]};

    // Converter stub: acknowledge a held request after lat[u] extra cycles.
    always @(posedge clk) begin
        for (int u = 0; u < 2; u++) begin
            if (conv_ack[u]) begin
                conv_ack[u] <= 1'b0;
                cnt[u] <= 0;
            end else if (conv_req[u]) begin
                if (cnt[u] >= lat[u]) conv_ack[u] <= 1'b1;
                else cnt[u] <= cnt[u] + 1;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Set up a unit and produce a 0-then-1 start; launch edge follows.
    task automatic launch(int u, logic [NCH-1:0] map, logic [1:0] code, logic inv);
        @(negedge clk);
        pad_map[u*NCH +: NCH] = map;
        wcode[2*u +: 2] = code;
        inv_en[u] = inv;
        start[u] = 1'b0;
        @(negedge clk);
        start[u] = 1'b1;
    endtask

    task automatic wait_done(int u);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done[u] && !busy[u]) break;
        end
    endtask

    task automatic t_reset();
        chk("R1 done", 32'(done), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 req", 32'(conv_req), 0);
        chk("R1 result", 32'(result), 0);
        att_rd_unit = 1'b0; #1;
        chk("R1 atten u1", 32'(att_rd_word), 0);
        att_rd_unit = 1'b1; #1;
        chk("R1 atten u2", 32'(att_rd_word), 0);
    endtask

    task automatic t_edge();
        lat[0] = 1;
        stub_data[0] = 12'hABC;
        launch(0, 10'b00_0010_0000, 2'd3, 1'b0);
        @(negedge clk);
        chk("R2 req after edge", 32'(conv_req[0]), 1);
        chk("R2 busy after edge", 32'(busy[0]), 1);
        chk("R2 chan index", 32'(conv_chan[0 +: CHW]), 5);
        wait_done(0);
        chk("R4 code3 12 bits", 32'(result[0 +: DW]), 32'hABC);
        repeat (5) @(negedge clk);
        chk("R2 no relaunch while high", 32'(busy[0]), 0);
    endtask

    task automatic t_widths();
        stub_data[1] = 12'hABC;
        lat[1] = 0;
        launch(1, 10'b00_0000_0001, 2'd0, 1'b0);
        wait_done(1);
        chk("R4 code0 9 bits", 32'(result[DW +: DW]), 32'h157);
        launch(1, 10'b00_0000_0001, 2'd2, 1'b0);
        wait_done(1);
        chk("R4 code2 11 bits", 32'(result[DW +: DW]), 32'h55E);
        launch(1, 10'b00_0000_0001, 2'd0, 1'b1);
        wait_done(1);
        chk("R5 invert 9 bits", 32'(result[DW +: DW]), 32'h0A8);
        launch(0, 10'b00_0000_0100, 2'd1, 1'b1);
        wait_done(0);
        chk("R5 invert 10 bits", 32'(result[0 +: DW]), 32'h150);
        chk("R5 other unit untouched", 32'(result[DW +: DW]), 32'h0A8);
    endtask

    task automatic t_invalid();
        launch(0, 10'b00_0000_0000, 2'd3, 1'b0);
        repeat (4) @(negedge clk);
        chk("R3 zero map no req", 32'(conv_req[0]), 0);
        chk("R3 zero map done kept", 32'(done[0]), 1);
        launch(0, 10'b00_0001_1000, 2'd3, 1'b0);
        repeat (4) @(negedge clk);
        chk("R3 multi-hot no busy", 32'(busy[0]), 0);
        chk("R3 multi-hot done kept", 32'(done[0]), 1);
    endtask

    task automatic t_done_timing();
        logic seen = 1'b0;
        lat[1] = 3;
        stub_data[1] = 12'h5A5;
        launch(1, 10'b10_0000_0000, 2'd3, 1'b0);
        @(negedge clk);
        chk("R6 done cleared on accept", 32'(done[1]), 0);
        for (int i = 0; i < 50; i++) begin
            if (conv_ack[1]) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        chk("R6 ack observed", 32'(seen), 1);
        chk("R6 done low while ack pending", 32'(done[1]), 0);
        @(negedge clk);
        chk("R6 done set on ack edge", 32'(done), 32'b11);
        chk("R6 result loaded", 32'(result[DW +: DW]), 32'h5A5);
    endtask

    task automatic t_hold_u1();
        lat[0] = 8;
        launch(0, 10'b00_0000_0010, 2'd3, 1'b0);
        repeat (2) @(negedge clk);
        chk("R7 busy before retrigger", 32'(busy[0]), 1);
        start[0] = 1'b0;
        pad_map[0 +: NCH] = 10'b01_0000_0000;
        @(negedge clk);
        start[0] = 1'b1;
        wait_done(0);
        chk("R7 first done", 32'(done[0]), 1);
        @(negedge clk);
        chk("R7 held start launched", 32'(busy[0]), 1);
        chk("R7 new channel", 32'(conv_chan[0 +: CHW]), 8);
        wait_done(0);
    endtask

    task automatic t_drop_u2();
        lat[1] = 8;
        launch(1, 10'b00_0000_0010, 2'd3, 1'b0);
        repeat (2) @(negedge clk);
        start[1] = 1'b0;
        @(negedge clk);
        start[1] = 1'b1;
        wait_done(1);
        repeat (4) @(negedge clk);
        chk("R8 dropped start stays idle", 32'(busy[1]), 0);
        chk("R8 done kept", 32'(done[1]), 1);
    endtask

    task automatic att_write(logic u, int c, logic [1:0] v);
        @(negedge clk);
        att_we = 1'b1; att_unit = u; att_chan = CHW'(c); att_val = v;
        @(negedge clk);
        att_we = 1'b0;
    endtask

    task automatic t_atten();
        att_write(1'b0, 3, 2'd2);
        att_write(1'b0, 5, 2'd1);
        att_rd_unit = 1'b0; #1;
        chk("R9 fields 3 and 5", 32'(att_rd_word), (2 << 6) | (1 << 10));
        att_write(1'b0, 3, 2'd1);
        #1;
        chk("R9 rewrite keeps neighbour", 32'(att_rd_word), (1 << 6) | (1 << 10));
        att_rd_unit = 1'b1; #1;
        chk("R9 other unit untouched", 32'(att_rd_word), 0);
        lat[0] = 4;
        launch(0, 10'b00_0000_1000, 2'd3, 1'b0);
        @(negedge clk);
        chk("R9 request carries atten", 32'(conv_atten[1:0]), 1);
        wait_done(0);
    endtask

    initial begin
        lat[0] = 0; lat[1] = 0; cnt[0] = 0; cnt[1] = 0;
        stub_data[0] = '0; stub_data[1] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_edge();
        t_widths();
        t_invalid();
        t_done_timing();
        t_hold_u1();
        t_drop_u2();
        t_atten();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule